// File: doc/BRIEF.md
# Alternate-Space MMU Register Access Decoder

This block sits beside a load/store unit and handles the accesses that carry an 8-bit address-space identifier (ASI). It checks each access against the current privilege level. It then steers the access to one of three targets: a 64-bit load/store control register, a 16-entry instruction-side MMU register bank, or a 16-entry data-side MMU register bank. Any other identifier reads as zero, and writes to it are dropped.

Writes to the banks follow rules set per register. Some entries are read-only. Some swallow writes silently. The fault-status entry clears itself, and on the data side also the fault-address entry, whenever the written word has its low bit clear. When a write changes the MMU enable bits held in the control register, the block raises a one-cycle request for the translation buffers to flush. Read results are registered and appear one cycle after the request.

Top module: `asi_reg_decoder`

## Requirements
- R1: An access whose ASI is below 0x80, made while `priv` is 0, is suppressed. It changes no register, raises no `rd_valid` and no `tlb_flush`, and `priv_err` pulses high for exactly the one cycle after the request.
- R2: ASI 0x45 reads and writes the control register. A write keeps only data bit 2 (instruction-side MMU enable) and bit 3 (data-side MMU enable). All other bits read as zero.
- R3: `tlb_flush` pulses for one cycle, one cycle after a permitted write to ASI 0x45, only when the stored value changes. A write that leaves the value unchanged raises no pulse.
- R4: ASI 0x50 selects the instruction-side bank and ASI 0x58 selects the data-side bank. The entry index is address bits 6:3, and other address bits have no effect. A permitted read sets `rd_valid` with the entry's value one cycle after the request. The two banks are independent.
- R5: In both banks, writes to entries 0 and 4 are ignored, so those entries read zero.
- R6: In the instruction-side bank, writes to entries 1, 2, 7 and 8 are also ignored. In the data-side bank, entry 1 is writable.
- R7: A write to entry 3 with data bit 0 set stores the data. With bit 0 clear, it stores zero. On the data side it also clears entry 4.
- R8: A read of any ASI other than 0x45, 0x50 and 0x58 returns zero with `rd_valid` set. A write to such an ASI changes no register and raises no `tlb_flush`.
- R9: Reset is synchronous and active high, and clears every register and output. `rd_data` is zero in every cycle where `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_asi | input | 8 | Address-space identifier |
| req_addr | input | ADDR_W (64) | Access address |
| req_wdata | input | DATA_W (64) | Store data |
| priv | input | 1 | Current mode is privileged |
| rd_data | output | DATA_W (64) | Registered load result |
| rd_valid | output | 1 | Load result valid |
| priv_err | output | 1 | Privilege-violation pulse |
| tlb_flush | output | 1 | Translation-buffer flush pulse |

## Verification
The assertions check the rules that hold on every cycle. They cover the timing and exclusivity of the privilege pulse, the masking of control-register reads, the causes of the flush pulse, zero read data for unknown identifiers and when no result is present, and the permanent zero of entries 0 and 4. The stored-state rules can only be shown by the bench's write-then-read sequences. These are the ignored entries that differ by bank, the fault-status clear and its side effect, bank independence, suppression of a denied store, and the flush that depends on the previous value.

// File: rtl/asi_dec_pkg.sv
package asi_dec_pkg;
  localparam logic [7:0] ASI_CTRL     = 8'h45;
  localparam logic [7:0] ASI_IBANK    = 8'h50;
  localparam logic [7:0] ASI_DBANK    = 8'h58;
  localparam logic [7:0] ASI_PRIV_LIM = 8'h80;

  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_CTRL  = 2'd1,
    TGT_IBANK = 2'd2,
    TGT_DBANK = 2'd3
  } asi_tgt_e;
endpackage

// File: rtl/asi_decode.sv
module asi_decode
  import asi_dec_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int IDX_W   = 4,
  parameter int IDX_LSB = 3
) (
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [7:0]        req_asi,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              priv,
  output logic              viol,
  output logic              do_read,
  output logic              do_write,
  output asi_tgt_e          tgt,
  output logic [IDX_W-1:0]  idx
);
  localparam int IDX_MSB = IDX_LSB + IDX_W - 1;

  logic restricted;
  logic granted;
  logic unused_addr;

  assign restricted  = req_asi < ASI_PRIV_LIM;
  assign viol        = req_valid && restricted && !priv;
  assign granted     = req_valid && !viol;
  assign do_read     = granted && !req_write;
  assign do_write    = granted && req_write;
  assign idx         = req_addr[IDX_MSB:IDX_LSB];
  assign unused_addr = ^{req_addr[ADDR_W-1:IDX_MSB+1], req_addr[IDX_LSB-1:0]};

  always_comb begin
    case (req_asi)
      ASI_CTRL:  tgt = TGT_CTRL;
      ASI_IBANK: tgt = TGT_IBANK;
      ASI_DBANK: tgt = TGT_DBANK;
      default:   tgt = TGT_NONE;
    endcase
  end
endmodule

// File: rtl/asi_lsu_ctrl.sv
module asi_lsu_ctrl #(
  parameter int              DATA_W    = 64,
  parameter logic [DATA_W-1:0] KEEP_MASK = 64'hC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] value,
  output logic              flush
);
  logic [DATA_W-1:0] value_q;
  logic [DATA_W-1:0] next_val;
  logic              flush_q;

  assign next_val = wdata & KEEP_MASK;

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= wr_en && (next_val != value_q);
      if (wr_en) value_q <= next_val;
    end
  end

  assign value = value_q;
  assign flush = flush_q;
endmodule

// File: rtl/asi_mmu_bank.sv
module asi_mmu_bank #(
  parameter int DATA_W   = 64,
  parameter int DEPTH    = 16,
  parameter bit IS_DSIDE = 1'b0,
  localparam int IDX_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rd_val
);
  localparam int FSR_IDX = 3;
  localparam int FAR_IDX = 4;

  logic [DATA_W-1:0] regs [DEPTH];

  function automatic logic locked(input logic [IDX_W-1:0] i);
    if (i == IDX_W'(0) || i == IDX_W'(FAR_IDX)) return 1'b1;
    if (!IS_DSIDE && (i == IDX_W'(1) || i == IDX_W'(2) ||
                      i == IDX_W'(7) || i == IDX_W'(8))) return 1'b1;
    return 1'b0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) regs[k] <= '0;
    end else if (wr_en && !locked(idx)) begin
      if (idx == IDX_W'(FSR_IDX) && !wdata[0]) begin
        regs[FSR_IDX] <= '0;
        if (IS_DSIDE) regs[FAR_IDX] <= '0;
      end else begin
        regs[idx] <= wdata;
      end
    end
  end

  assign rd_val = regs[idx];
endmodule

// File: rtl/asi_reg_decoder.sv
module asi_reg_decoder
  import asi_dec_pkg::*;
#(
  parameter int                ADDR_W    = 64,
  parameter int                DATA_W    = 64,
  parameter int                DEPTH     = 16,
  parameter int                IDX_LSB   = 3,
  parameter logic [DATA_W-1:0] KEEP_MASK = 64'hC
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [7:0]        req_asi,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              priv,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              priv_err,
  output logic              tlb_flush
);
  localparam int IDX_W = $clog2(DEPTH);

  logic              viol, do_read, do_write;
  asi_tgt_e          tgt;
  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] ctrl_val;
  logic [DATA_W-1:0] bank_val [2];
  logic [DATA_W-1:0] sel_val;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q, priv_err_q;

  asi_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_dec (
    .req_valid(req_valid), .req_write(req_write), .req_asi(req_asi),
    .req_addr(req_addr), .priv(priv), .viol(viol), .do_read(do_read),
    .do_write(do_write), .tgt(tgt), .idx(idx)
  );

  asi_lsu_ctrl #(.DATA_W(DATA_W), .KEEP_MASK(KEEP_MASK)) u_ctrl (
    .clk(clk), .rst(rst), .wr_en(do_write && tgt == TGT_CTRL),
    .wdata(req_wdata), .value(ctrl_val), .flush(tlb_flush)
  );

  for (genvar s = 0; s < 2; s++) begin : g_bank
    localparam asi_tgt_e MY_TGT = (s == 0) ? TGT_IBANK : TGT_DBANK;
    asi_mmu_bank #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IS_DSIDE(s == 1)) u_bank (
      .clk(clk), .rst(rst), .wr_en(do_write && tgt == MY_TGT),
      .idx(idx), .wdata(req_wdata), .rd_val(bank_val[s])
    );
  end

  always_comb begin
    case (tgt)
      TGT_CTRL:  sel_val = ctrl_val;
      TGT_IBANK: sel_val = bank_val[0];
      TGT_DBANK: sel_val = bank_val[1];
      default:   sel_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
      priv_err_q <= 1'b0;
    end else begin
      rd_valid_q <= do_read;
      rd_data_q  <= do_read ? sel_val : '0;
      priv_err_q <= viol;
    end
  end

  assign rd_data  = rd_data_q;
  assign rd_valid = rd_valid_q;
  assign priv_err = priv_err_q;
endmodule

// File: rtl/asi_reg_decoder_chk.sv
module asi_reg_decoder_chk #(
  parameter int                ADDR_W    = 64,
  parameter int                DATA_W    = 64,
  parameter int                IDX_LSB   = 3,
  parameter logic [DATA_W-1:0] KEEP_MASK = 64'hC
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [7:0]        req_asi,
  input logic [ADDR_W-1:0] req_addr,
  input logic [DATA_W-1:0] req_wdata,
  input logic              priv,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              priv_err,
  input logic              tlb_flush
);
  logic [3:0] idx_lo;
  logic       is_bank;
  logic       unused_chk;
  assign idx_lo     = 4'(req_addr[IDX_LSB +: 3] | 3'b000) | {req_addr[IDX_LSB+3], 3'b000};
  assign is_bank    = (req_asi == 8'h50) || (req_asi == 8'h58);
  assign unused_chk = ^req_wdata;

  // R1
  viol_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_asi < 8'h80 && !priv) |=> (priv_err && !rd_valid && !tlb_flush));
  // R1
  viol_cause_chk: assert property (@(posedge clk) disable iff (rst)
    priv_err |-> $past(req_valid && req_asi < 8'h80 && !priv));
  // R2
  ctrl_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(req_asi) == 8'h45) |-> ((rd_data & ~KEEP_MASK) == '0));
  // R3
  flush_cause_chk: assert property (@(posedge clk) disable iff (rst)
    tlb_flush |-> $past(req_valid && req_write && req_asi == 8'h45 && priv));
  // R4
  read_cause_chk: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(req_valid && !req_write));
  // R5
  fixed_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(is_bank) && ($past(idx_lo) == 4'd0 || $past(idx_lo) == 4'd4))
      |-> (rd_data == '0));
  // R8
  unknown_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && $past(req_asi) != 8'h45 && !$past(is_bank)) |-> (rd_data == '0));
  // R9
  idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> (rd_data == '0));
endmodule

bind asi_reg_decoder asi_reg_decoder_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_LSB(IDX_LSB), .KEEP_MASK(KEEP_MASK)
) u_chk (.*);

// File: tb/tb_asi_reg_decoder.sv
module tb_asi_reg_decoder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, priv = 1'b0;
  logic [7:0]  req_asi = '0;
  logic [63:0] req_addr = '0, req_wdata = '0;
  logic [63:0] rd_data;
  logic        rd_valid, priv_err, tlb_flush;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  asi_reg_decoder dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_asi(req_asi), .req_addr(req_addr), .req_wdata(req_wdata), .priv(priv),
    .rd_data(rd_data), .rd_valid(rd_valid), .priv_err(priv_err), .tlb_flush(tlb_flush)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  asi;
    logic [3:0]  idx;
    logic [63:0] wdata;
    logic        pv;
    logic        ev;
    logic [63:0] ed;
    logic        ep;
    logic        ef;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 40;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 8'h45, 4'd0, 64'hFF,   1'b1, 1'b0, 64'h0,    1'b0, 1'b1, 4'd3}, // R3 change
    '{1'b0, 8'h45, 4'd0, 64'h0,    1'b1, 1'b1, 64'hC,    1'b0, 1'b0, 4'd2}, // R2 mask
    '{1'b1, 8'h45, 4'd0, 64'hC,    1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd3}, // R3 same
    '{1'b1, 8'h45, 4'd0, 64'h0,    1'b0, 1'b0, 64'h0,    1'b1, 1'b0, 4'd1}, // R1 denied
    '{1'b0, 8'h45, 4'd0, 64'h0,    1'b1, 1'b1, 64'hC,    1'b0, 1'b0, 4'd1}, // R1 kept
    '{1'b1, 8'h50, 4'd5, 64'h1234, 1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd4},
    '{1'b0, 8'h50, 4'd5, 64'h0,    1'b1, 1'b1, 64'h1234, 1'b0, 1'b0, 4'd4}, // R4
    '{1'b1, 8'h58, 4'd5, 64'h5678, 1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd4},
    '{1'b0, 8'h58, 4'd5, 64'h0,    1'b1, 1'b1, 64'h5678, 1'b0, 1'b0, 4'd4},
    '{1'b0, 8'h50, 4'd5, 64'h0,    1'b1, 1'b1, 64'h1234, 1'b0, 1'b0, 4'd4}, // R4 independent
    '{1'b1, 8'h50, 4'd1, 64'hAA,   1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd6},
    '{1'b0, 8'h50, 4'd1, 64'h0,    1'b1, 1'b1, 64'h0,    1'b0, 1'b0, 4'd6}, // R6
    '{1'b1, 8'h50, 4'd8, 64'hBB,   1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd6},
    '{1'b0, 8'h50, 4'd8, 64'h0,    1'b1, 1'b1, 64'h0,    1'b0, 1'b0, 4'd6},
    '{1'b1, 8'h58, 4'd1, 64'hAA,   1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd6},
    '{1'b0, 8'h58, 4'd1, 64'h0,    1'b1, 1'b1, 64'hAA,   1'b0, 1'b0, 4'd6},
    '{1'b1, 8'h50, 4'd0, 64'h55,   1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd5},
    '{1'b0, 8'h50, 4'd0, 64'h0,    1'b1, 1'b1, 64'h0,    1'b0, 1'b0, 4'd5}, // R5
    '{1'b1, 8'h58, 4'd4, 64'h77,   1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd5},
    '{1'b0, 8'h58, 4'd4, 64'h0,    1'b1, 1'b1, 64'h0,    1'b0, 1'b0, 4'd5},
    '{1'b1, 8'h50, 4'd3, 64'hF1,   1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd7},
    '{1'b0, 8'h50, 4'd3, 64'h0,    1'b1, 1'b1, 64'hF1,   1'b0, 1'b0, 4'd7}, // R7 set
    '{1'b1, 8'h50, 4'd3, 64'hF0,   1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd7},
    '{1'b0, 8'h50, 4'd3, 64'h0,    1'b1, 1'b1, 64'h0,    1'b0, 1'b0, 4'd7}, // R7 clear
    '{1'b1, 8'h58, 4'd3, 64'h81,   1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd7},
    '{1'b0, 8'h58, 4'd3, 64'h0,    1'b1, 1'b1, 64'h81,   1'b0, 1'b0, 4'd7},
    '{1'b1, 8'h58, 4'd3, 64'h80,   1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd7},
    '{1'b0, 8'h58, 4'd3, 64'h0,    1'b1, 1'b1, 64'h0,    1'b0, 1'b0, 4'd7},
    '{1'b0, 8'h58, 4'd4, 64'h0,    1'b1, 1'b1, 64'h0,    1'b0, 1'b0, 4'd7},
    '{1'b0, 8'h80, 4'd0, 64'h0,    1'b0, 1'b1, 64'h0,    1'b0, 1'b0, 4'd8}, // R8 unpriv ok
    '{1'b1, 8'h46, 4'd0, 64'hFF,   1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd8},
    '{1'b0, 8'h45, 4'd0, 64'h0,    1'b1, 1'b1, 64'hC,    1'b0, 1'b0, 4'd8},
    '{1'b0, 8'h46, 4'd0, 64'h0,    1'b1, 1'b1, 64'h0,    1'b0, 1'b0, 4'd8},
    '{1'b0, 8'h58, 4'd5, 64'h0,    1'b0, 1'b0, 64'h0,    1'b1, 1'b0, 4'd1}, // R1 read
    '{1'b1, 8'h58, 4'd5, 64'h0,    1'b0, 1'b0, 64'h0,    1'b1, 1'b0, 4'd1},
    '{1'b0, 8'h58, 4'd5, 64'h0,    1'b1, 1'b1, 64'h5678, 1'b0, 1'b0, 4'd1},
    '{1'b1, 8'h45, 4'd0, 64'h0,    1'b1, 1'b0, 64'h0,    1'b0, 1'b1, 4'd3},
    '{1'b0, 8'h45, 4'd0, 64'h0,    1'b1, 1'b1, 64'h0,    1'b0, 1'b0, 4'd2},
    '{1'b1, 8'h58, 4'd15,64'hDEAD, 1'b1, 1'b0, 64'h0,    1'b0, 1'b0, 4'd4},
    '{1'b0, 8'h58, 4'd15,64'h0,    1'b1, 1'b1, 64'hDEAD, 1'b0, 1'b0, 4'd4}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Issue one request; outputs are sampled 1 ns after the edge that registers it.
  task automatic access(input logic wr, input logic [7:0] asi, input logic [3:0] idx,
                        input logic [63:0] wd, input logic pv);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_asi = asi; priv = pv; req_wdata = wd;
    req_addr  = 64'hF0F0_0000_0000_0F00 | (64'(idx) << 3) | 64'h7;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk); #1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1;
        // R9 reset state
        check("R9 rd_valid in reset", 64'(rd_valid), 64'd0);
        check("R9 rd_data in reset", rd_data, 64'd0);
        @(negedge clk); rst = 1'b0;
        access(1'b0, 8'h45, 4'd0, 64'h0, 1'b1);
        check("R9 ctrl after reset", rd_data, 64'd0);
        check("R9 valid after reset read", 64'(rd_valid), 64'd1);

        for (int i = 0; i < NV; i++) begin
          access(TBL[i].wr, TBL[i].asi, TBL[i].idx, TBL[i].wdata, TBL[i].pv);
          check($sformatf("R%0d vec%0d rd_valid", TBL[i].req, i), 64'(rd_valid), 64'(TBL[i].ev));
          check($sformatf("R%0d vec%0d rd_data", TBL[i].req, i), rd_data, TBL[i].ed);
          check($sformatf("R%0d vec%0d priv_err", TBL[i].req, i), 64'(priv_err), 64'(TBL[i].ep));
          check($sformatf("R%0d vec%0d tlb_flush", TBL[i].req, i), 64'(tlb_flush), 64'(TBL[i].ef));
        end

        // R1 and R3: pulses last one cycle only
        access(1'b1, 8'h45, 4'd0, 64'h4, 1'b1);
        check("R3 flush pulse", 64'(tlb_flush), 64'd1);
        idle_cycle();
        check("R3 flush drops", 64'(tlb_flush), 64'd0);
        access(1'b0, 8'h50, 4'd3, 64'h0, 1'b0);
        check("R1 viol pulse", 64'(priv_err), 64'd1);
        idle_cycle();
        check("R1 viol drops", 64'(priv_err), 64'd0);
        check("R9 idle rd_data zero", rd_data, 64'd0);

        // R9: reset mid-run clears banks and control
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        access(1'b0, 8'h58, 4'd5, 64'h0, 1'b1);
        check("R9 bank cleared by reset", rd_data, 64'd0);
        access(1'b0, 8'h45, 4'd0, 64'h0, 1'b1);
        check("R9 ctrl cleared by reset", rd_data, 64'd0);
      end
      begin
        repeat (5000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule